// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the status and protection state of a small serial NOR flash with a 256 KB array. It decides, for every program, erase or status-write request, whether the request may proceed. The state it keeps is the write-enable latch, the auto-increment programming flag, the two-bit block-protect field, the protect-lock bit, and separate lock bits for the top and bottom 4 KB sectors. A command decoder sits upstream and hands it one decoded request at a time, with an inclusive target address range. An array sequencer sits downstream and starts work on a `go` pulse, then reports the end of that work on `op_done`.

Requests enter through a valid/ready handshake. A request is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as an accepted operation is busy. The sender holds `cmd_op`, `cmd_lo`, `cmd_hi` and `cmd_wdata` stable while `cmd_valid` is high and `cmd_ready` is low. The `wp_n` pin is sampled on the cycle a request is taken. One cycle after it takes a request, the block raises either a `go` pulse, a `reject` pulse, or neither. The status byte is always visible on `status`.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, `status` reads 0x0C: both block-protect bits are 1, and lock, sector locks, write-enable, busy and AAI are all 0. `cmd_ready` is 1 and `go` and `reject` are 0.
- R2: Opcode 0 (write enable) sets status bit1. Opcode 1 (write disable) clears bit1 and bit6. The status layout is: bit0 busy, bit1 write-enable, bit2 BP0, bit3 BP1, bit4 bottom-sector lock, bit5 top-sector lock, bit6 AAI mode, bit7 protect lock.
- R3: The block-protect field {bit3,bit2} selects the protected range. 00 protects nothing, 01 protects 0x30000–0x3FFFF, 10 protects 0x20000–0x3FFFF, and 11 protects the whole array. A program or erase whose range [lo,hi] touches the protected range is rejected.
- R4: Opcode 2 (status write) copies `cmd_wdata` bits 2, 3, 4, 5 and 7 into the same status bits. When `wp_n` is 0 and bit7 is 1, the request is rejected and those five bits keep their values. While `wp_n` is 1, bit7 does not block the write.
- R5: Opcode 7 (chip erase) is rejected unless both block-protect bits are 0.
- R6: With bit5 set, any program or erase whose range reaches 0x3F000–0x3FFFF is rejected. With bit4 set, any whose range reaches 0x00000–0x00FFF is rejected. Chip erase counts as covering the whole array.
- R7: Opcodes 2 to 7 arriving while the write-enable bit is 0 produce no `go` and no `reject`, and leave `status` unchanged.
- R8: An accepted request gives a one-cycle `go`, sets busy, and drops `cmd_ready` until `op_done`. For opcodes 2, 3, 5, 6 and 7, write-enable clears on `op_done`.
- R9: A rejected request gives a one-cycle `reject`, does not set busy, and leaves write-enable at 1.
- R10: An accepted opcode 4 (AAI program) sets bit6. Bit6 and write-enable stay 1 after `op_done`, unless `hi` equals the highest unprotected address. In that case both clear on `op_done`.
- R11: While bit6 is 1, every opcode except 1 and 4 produces no pulse and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request can be taken (not busy) |
| cmd_op | input | 3 | Decoded opcode 0..7 |
| cmd_lo | input | 18 | Lowest byte address of the target range |
| cmd_hi | input | 18 | Highest byte address of the target range |
| cmd_wdata | input | 8 | Status-write data |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Completion strobe from the array sequencer |
| go | output | 1 | One-cycle pulse: request accepted |
| reject | output | 1 | One-cycle pulse: request refused |
| status | output | 8 | Status byte |

## Verification
Every result of a request taken at a rising edge is registered at that edge. `go`, `reject`, busy, `cmd_ready` and the written protect bits can therefore all be read at the next falling edge. The write-enable and AAI clearing that follows completion appears one edge after `op_done` is sampled. The bench drives inputs and samples outputs only on falling edges. It checks the decision at the first falling edge after the request is taken, then pulses `op_done` for one cycle, and checks `status` at the falling edge after that.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [2:0] {
    OP_WREN   = 3'd0,
    OP_WRDI   = 3'd1,
    OP_WRSR   = 3'd2,
    OP_PROG   = 3'd3,
    OP_AAI    = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_CERASE = 3'd7
  } op_e;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_BP0  = 2;
  localparam int ST_BP1  = 3;
  localparam int ST_BSP  = 4;
  localparam int ST_TSP  = 5;
  localparam int ST_AAI  = 6;
  localparam int ST_BPL  = 7;

  // True for every opcode that needs the write-enable latch.
  function automatic logic needs_wel(op_e op);
    return (op != OP_WREN) && (op != OP_WRDI);
  endfunction

endpackage

// File: rtl/wprot_zone.sv
// Range check: block-protect window, sector locks, chip-erase rule.
module wprot_zone #(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 12
) (
  input  logic [1:0]        bp,
  input  logic              tsp,
  input  logic              bsp,
  input  logic              is_ce,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              veto,
  output logic              at_free_top
);

  localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W:0] SECT = {{ADDR_W{1'b0}}, 1'b1} << SECT_W;
  localparam logic [ADDR_W:0] TOP_BASE = FULL - SECT;

  logic [ADDR_W:0] prot_size;
  logic [ADDR_W:0] prot_base;
  logic [ADDR_W:0] lo_x, hi_x;
  logic            hit_block, hit_top, hit_bot, hit_ce;

  assign lo_x = {1'b0, lo};
  assign hi_x = {1'b0, hi};

  // Protected window grows downward from the top of the array.
  always_comb begin
    case (bp)
      2'b01:   prot_size = FULL >> 2;
      2'b10:   prot_size = FULL >> 1;
      2'b11:   prot_size = FULL;
      default: prot_size = '0;
    endcase
    prot_base = FULL - prot_size;
  end

  assign hit_block = (bp != 2'b00) && (hi_x >= prot_base);
  assign hit_top   = tsp && (hi_x >= TOP_BASE);
  assign hit_bot   = bsp && (lo_x < SECT);
  assign hit_ce    = is_ce && (bp != 2'b00);

  assign veto = hit_block | hit_top | hit_bot | hit_ce;

  // Highest unprotected address reached by the request's upper end.
  assign at_free_top = (bp != 2'b11) && (hi_x == (prot_base - 1'b1));

endmodule

// File: rtl/wprot_lockreg.sv
// Protection bits with pin-qualified lock-down.
module wprot_lockreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_bp,
  input  logic       wr_bpl,
  input  logic       wr_tsp,
  input  logic       wr_bsp,
  input  logic       wp_n,
  output logic [1:0] bp,
  output logic       bpl,
  output logic       tsp,
  output logic       bsp,
  output logic       frozen
);

  // Lock only bites while the pin is held low.
  assign frozen = !wp_n && bpl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp  <= 2'b11;
      bpl <= 1'b0;
      tsp <= 1'b0;
      bsp <= 1'b0;
    end else if (wr_en && !frozen) begin
      bp  <= wr_bp;
      bpl <= wr_bpl;
      tsp <= wr_tsp;
      bsp <= wr_bsp;
    end
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable({bp, bpl, tsp, bsp}));  // R4

endmodule

// File: rtl/wprot_seq.sv
// Write-enable latch, AAI mode, busy tracking and decision pulses.
module wprot_seq
  import wprot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  op_e  op,
  input  logic veto,
  input  logic frozen,
  input  logic at_free_top,
  input  logic op_done,
  output logic wel,
  output logic aai,
  output logic busy,
  output logic go,
  output logic reject,
  output logic sr_commit
);

  logic take_wren, take_wrdi, take_op, bad, good;
  logic pend_wel_clr, pend_aai_end;

  always_comb begin
    take_wren = acc && (op == OP_WREN) && !aai;
    take_wrdi = acc && (op == OP_WRDI);
    take_op   = acc && needs_wel(op) && wel && (!aai || op == OP_AAI);
    bad       = take_op && ((op == OP_WRSR) ? frozen : veto);
    good      = take_op && !bad;
    sr_commit = good && (op == OP_WRSR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel          <= 1'b0;
      aai          <= 1'b0;
      busy         <= 1'b0;
      go           <= 1'b0;
      reject       <= 1'b0;
      pend_wel_clr <= 1'b0;
      pend_aai_end <= 1'b0;
    end else begin
      go     <= good;
      reject <= bad;
      if (take_wren) wel <= 1'b1;
      if (take_wrdi) begin
        wel <= 1'b0;
        aai <= 1'b0;
      end
      if (good) begin
        busy         <= 1'b1;
        pend_wel_clr <= (op != OP_AAI);
        pend_aai_end <= (op == OP_AAI) && at_free_top;
        if (op == OP_AAI) aai <= 1'b1;
      end
      if (busy && op_done) begin
        busy <= 1'b0;
        if (pend_wel_clr) wel <= 1'b0;
        if (pend_aai_end) begin
          wel <= 1'b0;
          aai <= 1'b0;
        end
      end
    end
  end

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && reject));  // R9
  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> busy);  // R8
  AST_REJ_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (wel && !busy));  // R9
  AST_NO_WEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wel && needs_wel(op)) |=> (!go && !reject));  // R7
  AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done && pend_wel_clr) |=> !wel);  // R8
  AST_AAI_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    aai |-> wel);  // R10

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_lo,
  input  logic [ADDR_W-1:0] cmd_hi,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              go,
  output logic              reject,
  output logic [7:0]        status
);

  localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W:0] SECT = {{ADDR_W{1'b0}}, 1'b1} << SECT_W;

  op_e               op;
  logic              acc, is_ce;
  logic [ADDR_W-1:0] eff_lo, eff_hi;
  logic [1:0]        bp;
  logic              bpl, tsp, bsp, frozen;
  logic              veto, at_free_top;
  logic              wel, aai, busy, sr_commit;
  logic              unused_wbits;

  assign op           = op_e'(cmd_op);
  assign acc          = cmd_valid && cmd_ready;
  assign cmd_ready    = !busy;
  assign is_ce        = (op == OP_CERASE);
  assign eff_lo       = is_ce ? '0 : cmd_lo;
  assign eff_hi       = is_ce ? '1 : cmd_hi;
  assign unused_wbits = ^{cmd_wdata[ST_AAI], cmd_wdata[ST_WEL], cmd_wdata[ST_BUSY]};

  wprot_zone #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_zone (
    .bp          (bp),
    .tsp         (tsp),
    .bsp         (bsp),
    .is_ce       (is_ce),
    .lo          (eff_lo),
    .hi          (eff_hi),
    .veto        (veto),
    .at_free_top (at_free_top)
  );

  wprot_lockreg u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (sr_commit),
    .wr_bp  ({cmd_wdata[ST_BP1], cmd_wdata[ST_BP0]}),
    .wr_bpl (cmd_wdata[ST_BPL]),
    .wr_tsp (cmd_wdata[ST_TSP]),
    .wr_bsp (cmd_wdata[ST_BSP]),
    .wp_n   (wp_n),
    .bp     (bp),
    .bpl    (bpl),
    .tsp    (tsp),
    .bsp    (bsp),
    .frozen (frozen)
  );

  wprot_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .op          (op),
    .veto        (veto),
    .frozen      (frozen),
    .at_free_top (at_free_top),
    .op_done     (op_done),
    .wel         (wel),
    .aai         (aai),
    .busy        (busy),
    .go          (go),
    .reject      (reject),
    .sr_commit   (sr_commit)
  );

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_WEL]  = wel;
    status[ST_BP0]  = bp[0];
    status[ST_BP1]  = bp[1];
    status[ST_BSP]  = bsp;
    status[ST_TSP]  = tsp;
    status[ST_AAI]  = aai;
    status[ST_BPL]  = bpl;
  end

  AST_CE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_CERASE && bp != 2'b00) |=> !go);  // R5
  AST_TOP_SECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_PROG && tsp && ({1'b0, cmd_hi} >= FULL - SECT)) |=> !go);  // R6
  AST_BOT_SECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_PROG && bsp && ({1'b0, cmd_lo} < SECT)) |=> !go);  // R6
  AST_FULL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_PROG && bp == 2'b11) |=> !go);  // R3

endmodule

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [17:0] cmd_lo = '0;
  logic [17:0] cmd_hi = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        wp_n = 1'b1;
  logic        op_done = 1'b0;
  logic        go, reject;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  wprot_ctrl u_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_wdata(cmd_wdata),
    .wp_n(wp_n), .op_done(op_done), .go(go), .reject(reject), .status(status)
  );

  // res: 0 none, 1 go, 2 reject
  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  op;
    logic [17:0] lo;
    logic [17:0] hi;
    logic [7:0]  wd;
    logic [1:0]  res;
    logic [7:0]  st;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h0E},  // R2 write enable
    '{4'd3,  3'd3, 18'h00000, 18'h00000, 8'h00, 2'd2, 8'h0E},  // R3 all protected
    '{4'd4,  3'd2, 18'h00000, 18'h00000, 8'h04, 2'd1, 8'h04},  // R4 set quarter
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h06},  // R2
    '{4'd3,  3'd3, 18'h30000, 18'h30000, 8'h00, 2'd2, 8'h06},  // R3 quarter edge
    '{4'd8,  3'd3, 18'h2FFFF, 18'h2FFFF, 8'h00, 2'd1, 8'h04},  // R8 clears WEL
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h06},  // R2
    '{4'd5,  3'd7, 18'h00000, 18'h00000, 8'h00, 2'd2, 8'h06},  // R5 CE blocked
    '{4'd4,  3'd2, 18'h00000, 18'h00000, 8'h08, 2'd1, 8'h08},  // R4 set half
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h0A},  // R2
    '{4'd3,  3'd5, 18'h20000, 18'h20FFF, 8'h00, 2'd2, 8'h0A},  // R3 half edge
    '{4'd3,  3'd5, 18'h1F000, 18'h1FFFF, 8'h00, 2'd1, 8'h08},  // R3 below half
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h0A},  // R2
    '{4'd4,  3'd2, 18'h00000, 18'h00000, 8'h30, 2'd1, 8'h30},  // R4 sector locks
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h32},  // R2
    '{4'd6,  3'd6, 18'h00000, 18'h0FFFF, 8'h00, 2'd2, 8'h32},  // R6 bottom lock
    '{4'd6,  3'd3, 18'h3F800, 18'h3F800, 8'h00, 2'd2, 8'h32},  // R6 top lock
    '{4'd6,  3'd3, 18'h10000, 18'h10000, 8'h00, 2'd1, 8'h30},  // R6 middle free
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h32},  // R2
    '{4'd6,  3'd7, 18'h00000, 18'h00000, 8'h00, 2'd2, 8'h32},  // R6 CE vs locks
    '{4'd4,  3'd2, 18'h00000, 18'h00000, 8'h00, 2'd1, 8'h00},  // R4 open all
    '{4'd2,  3'd0, 18'h00000, 18'h00000, 8'h00, 2'd0, 8'h02},  // R2
    '{4'd5,  3'd7, 18'h00000, 18'h00000, 8'h00, 2'd1, 8'h00},  // R5 CE allowed
    '{4'd7,  3'd3, 18'h00400, 18'h00400, 8'h00, 2'd0, 8'h00},  // R7 no WEL
    '{4'd7,  3'd2, 18'h00000, 18'h00000, 8'h0C, 2'd0, 8'h00}   // R7 no WEL
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Presents one request for one cycle; returns at the falling edge
  // after it was taken, with the decision pulses visible.
  task automatic issue(input logic [2:0] op, input logic [17:0] lo,
                       input logic [17:0] hi, input logic [7:0] wd,
                       output logic [1:0] res);
    @(negedge clk);
    cmd_op = op; cmd_lo = lo; cmd_hi = hi; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    res = {reject, go};
  endtask

  task automatic complete();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic run(string tag, input logic [2:0] op, input logic [17:0] lo,
                     input logic [17:0] hi, input logic [7:0] wd,
                     input logic [1:0] eres, input logic [7:0] est);
    logic [1:0] r;
    issue(op, lo, hi, wd, r);
    check(tag, {6'd0, r}, {6'd0, eres});
    if (r == 2'b01) complete();
    check(tag, status, est);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", status, 8'h0C);
    check("R1 ready/go/reject", {5'd0, cmd_ready, go, reject}, 8'h04);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vector %0d", VEC[i].rq, i);
      run(t, VEC[i].op, VEC[i].lo, VEC[i].hi, VEC[i].wd, VEC[i].res, VEC[i].st);
    end

    // Lock-down with the protect pin: R4, R9
    run("R4 wren",           3'd0, '0, '0, 8'h00, 2'd0, 8'h02);
    run("R4 set lock",       3'd2, '0, '0, 8'h80, 2'd1, 8'h80);
    wp_n = 1'b0;
    run("R4 wren pin low",   3'd0, '0, '0, 8'h00, 2'd0, 8'h82);
    run("R9 frozen write",   3'd2, '0, '0, 8'h0C, 2'd2, 8'h82);
    wp_n = 1'b1;
    run("R4 pin high write", 3'd2, '0, '0, 8'h8C, 2'd1, 8'h8C);
    run("R4 wren",           3'd0, '0, '0, 8'h00, 2'd0, 8'h8E);
    run("R4 unlock",         3'd2, '0, '0, 8'h00, 2'd1, 8'h00);

    // AAI mode: R8, R10, R11
    run("R2 wren", 3'd0, '0, '0, 8'h00, 2'd0, 8'h02);
    issue(3'd4, 18'h00100, 18'h00101, 8'h00, r);
    check("R10 aai go", {6'd0, r}, 8'h01);
    check("R8 busy status", status, 8'h43);
    check("R8 ready low", {7'd0, cmd_ready}, 8'h00);
    complete();
    check("R10 aai stays", status, 8'h42);
    run("R11 prog in aai",  3'd3, 18'h00200, 18'h00200, 8'h00, 2'd0, 8'h42);
    run("R11 wrsr in aai",  3'd2, '0, '0, 8'h0C, 2'd0, 8'h42);
    run("R10 aai next",     3'd4, 18'h00102, 18'h00103, 8'h00, 2'd1, 8'h42);
    run("R10 wrdi ends",    3'd1, '0, '0, 8'h00, 2'd0, 8'h00);
    run("R2 wren",          3'd0, '0, '0, 8'h00, 2'd0, 8'h02);
    run("R10 aai at top",   3'd4, 18'h3FFFE, 18'h3FFFF, 8'h00, 2'd1, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule